// File: doc/BRIEF.md
# Switching Regulator Start-up Sequencer and Fault Supervisor

This block is the digital supervisor of a synchronous buck controller. It counts switching-cycle ticks from the regulator oscillator. From that count it derives three things: a current-limit code that rises in steps during soft start, a delayed release of the active-low reset output, and a delayed arming of the output undervoltage checks. It also turns comparator flags into driver commands. Overvoltage on the output, or undervoltage on either supply, latches the regulator off and holds the low-side switch on. Shutdown and over-temperature put both gate drivers into tri-state.

The comparators, the DAC and the reference are outside the block and reach it as single-bit flags. The block has no data stream, so every pin is a plain control or status signal. The tick input must be a single-cycle pulse in the `clk` domain, and the flags must already be synchronised to `clk`. The block is active when `shdn_n` is high and `otemp` is low. Leaving the inactive state restarts the whole sequence.

Top module: `pwr_seq_supervisor`

## Requirements
- R1: While `shdn_n` is low, `drv_cmd` is tri-state (2'd0), `rst_out_n` is 0, `ilim_code` is 0 and `ldo_on` is 0. While the block is active and no fault is present, `drv_cmd` is run (2'd1).
- R2: After n ticks in the active state, `ilim_code` equals n / SS_STEP_TICKS (integer division). Code k stands for k quarters of full current limit. With the default of 128 ticks per step, full limit is reached after 512 ticks.
- R3: `rst_out_n` stays 0 until RST_TICKS ticks (default 32768) have been counted since the block became active.
- R4: `uv_flag`, and `ldo_uv` while `ldo_en` is high, have no effect until UV_ARM_TICKS ticks (default 5000) have been counted. After that, either flag drives `rst_out_n` to 0 while it is present, and the flag is not latched.
- R5: With the block active, `ov_flag` high sets `drv_cmd` to low-side-on (2'd2) in the same cycle. The state is latched and remains after `ov_flag` falls.
- R6: `vin_uv` or `v5_uv` high, with the block active, causes the same latched low-side-on state as R5. While that state holds, `ilim_code` is 0 and `rst_out_n` is 0.
- R7: `otemp` high acts like shutdown: `drv_cmd` is tri-state, `rst_out_n` is 0 and `ilim_code` is 0. The hysteresis of the flag is applied outside the block.
- R8: `ldo_on` equals `ldo_en` while the block is active. `ldo_en` low turns off only the linear regulator and its undervoltage check. It has no effect on `drv_cmd`, on the timers or on `ilim_code`.
- R9: Any clock edge spent inactive clears the fault latch and all three timers. When the block becomes active again, `drv_cmd` returns to run, `ilim_code` starts again from 0 and `rst_out_n` is 0 until the reset delay has passed again.
- R10: Each timer stops at its terminal count. Further ticks keep `ilim_code` at SS_LEVELS-1 (full limit) and keep the reset released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| tick | input | 1 | Single-cycle pulse once per switching cycle |
| shdn_n | input | 1 | Low puts the regulator into shutdown |
| ldo_en | input | 1 | High enables the linear regulator |
| ov_flag | input | 1 | Switcher output above nominal plus 10 % |
| uv_flag | input | 1 | Switcher output below nominal minus 10 % |
| vin_uv | input | 1 | Battery input below its undervoltage threshold |
| v5_uv | input | 1 | 5 V bias supply below its undervoltage threshold |
| otemp | input | 1 | Die over-temperature, hysteresis applied outside the block |
| ldo_uv | input | 1 | Linear output below nominal minus 10 % |
| ilim_code | output | $clog2(SS_LEVELS) | Soft-start current-limit step, in quarters of full limit |
| drv_cmd | output | 2 | Driver state: 0 tri-state, 1 run, 2 low-side on |
| ldo_on | output | 1 | Enable for the linear regulator gate driver |
| rst_out_n | output | 1 | Active-low reset for the load |

## Verification
The assertions assume that `tick` lasts one clock and that the flags are stable between clock edges. They also assume that the checker sees every cycle after `rst_n` is released, so that the one-step bound on `ilim_code` can compare against the value from the previous cycle. The bench changes every input only on the falling clock edge. It raises `tick` for exactly one cycle at a time and holds each flag for whole cycles, so the stimulus never leaves these assumptions. The bench is built with a small timer configuration in which undervoltage arming comes after the reset release. This order makes the ignored window of R4 visible on `rst_out_n`.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    DRV_TRI   = 2'd0,
    DRV_RUN   = 2'd1,
    DRV_LOWON = 2'd2
  } drv_e;
endpackage

// File: rtl/pwr_tick_timer.sv
// Saturating counter of switching-cycle ticks with a synchronous clear.
module pwr_tick_timer #(
  parameter int LIMIT = 16,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         done
);
  assign done = (cnt == W'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (tick && !done)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwr_softstart.sv
// Current-limit step generator: advances one level every STEP ticks.
module pwr_softstart #(
  parameter int STEP   = 128,
  parameter int LEVELS = 5,
  localparam int CW    = $clog2(LEVELS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          force_zero,
  output logic [CW-1:0] code
);
  localparam int SPAN = STEP * (LEVELS - 1);
  localparam int TW   = $clog2(SPAN + 1);

  logic [TW-1:0] cnt;
  logic          at_top;

  pwr_tick_timer #(.LIMIT(SPAN)) ramp_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
    .cnt(cnt), .done(at_top)
  );

  always_comb begin
    if (force_zero)  code = '0;
    else if (at_top) code = CW'(LEVELS - 1);
    else             code = CW'(32'(cnt) / STEP);
  end
endmodule

// File: rtl/pwr_fault_latch.sv
// Sticky fault flag, cleared only by the inactive state.
module pwr_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic trip,
  output logic held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held <= 1'b0;
    else if (clr)   held <= 1'b0;
    else if (trip)  held <= 1'b1;
  end
endmodule

// File: rtl/pwr_seq_supervisor.sv
module pwr_seq_supervisor
  import pwr_seq_pkg::*;
#(
  parameter int SS_STEP_TICKS = 128,
  parameter int SS_LEVELS     = 5,
  parameter int RST_TICKS     = 32768,
  parameter int UV_ARM_TICKS  = 5000,
  localparam int ILIM_W       = $clog2(SS_LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              shdn_n,
  input  logic              ldo_en,
  input  logic              ov_flag,
  input  logic              uv_flag,
  input  logic              vin_uv,
  input  logic              v5_uv,
  input  logic              otemp,
  input  logic              ldo_uv,
  output logic [ILIM_W-1:0] ilim_code,
  output logic [1:0]        drv_cmd,
  output logic              ldo_on,
  output logic              rst_out_n
);
  localparam int RW = $clog2(RST_TICKS + 1);
  localparam int UW = $clog2(UV_ARM_TICKS + 1);

  logic          active, idle_clr;
  logic          trip, fault_q, fault_now;
  logic          rst_done, uv_armed, out_low;
  logic [RW-1:0] rst_cnt;
  logic [UW-1:0] arm_cnt;
  drv_e          drv_state;

  assign active   = shdn_n & ~otemp;
  assign idle_clr = ~active;
  assign trip     = active & (ov_flag | vin_uv | v5_uv);

  pwr_fault_latch fault_i (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .trip(trip), .held(fault_q)
  );
  assign fault_now = fault_q | trip;

  pwr_softstart #(.STEP(SS_STEP_TICKS), .LEVELS(SS_LEVELS)) ss_i (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .tick(tick),
    .force_zero(fault_now | idle_clr), .code(ilim_code)
  );

  pwr_tick_timer #(.LIMIT(RST_TICKS)) rst_tmr_i (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .tick(tick),
    .cnt(rst_cnt), .done(rst_done)
  );

  pwr_tick_timer #(.LIMIT(UV_ARM_TICKS)) arm_tmr_i (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .tick(tick),
    .cnt(arm_cnt), .done(uv_armed)
  );

  assign ldo_on    = active & ldo_en;
  assign out_low   = uv_armed & (uv_flag | (ldo_on & ldo_uv));
  assign rst_out_n = active & ~fault_now & rst_done & ~out_low;

  always_comb begin
    if (!active)        drv_state = DRV_TRI;
    else if (fault_now) drv_state = DRV_LOWON;
    else                drv_state = DRV_RUN;
  end
  assign drv_cmd = drv_state;
endmodule

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker
  import pwr_seq_pkg::*;
#(
  parameter int LEVELS = 5,
  parameter int CW     = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shdn_n,
  input logic          otemp,
  input logic          ldo_en,
  input logic          ov_flag,
  input logic [CW-1:0] ilim_code,
  input logic [1:0]    drv_cmd,
  input logic          ldo_on,
  input logic          rst_out_n
);
  AST_SHDN_TRI: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |-> (drv_cmd == DRV_TRI && !rst_out_n && ilim_code == '0)); // R1
  AST_CODE_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, ilim_code} <= {1'b0, $past(ilim_code)} + 1'b1)); // R2
  AST_OV_LOWON: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_n && !otemp && ov_flag) |-> drv_cmd == DRV_LOWON); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_cmd == DRV_LOWON && shdn_n && !otemp) |=>
      (!shdn_n || otemp || drv_cmd == DRV_LOWON)); // R5
  AST_LOWON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    drv_cmd == DRV_LOWON |-> (!rst_out_n && ilim_code == '0)); // R6
  AST_OTEMP_TRI: assert property (@(posedge clk) disable iff (!rst_n)
    otemp |-> (drv_cmd == DRV_TRI && !rst_out_n)); // R7
  AST_LDO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ldo_en |-> !ldo_on); // R8
  AST_CODE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ilim_code) <= LEVELS - 1); // R10
endmodule

bind pwr_seq_supervisor pwr_seq_checker #(.LEVELS(SS_LEVELS), .CW(ILIM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .otemp(otemp), .ldo_en(ldo_en),
  .ov_flag(ov_flag), .ilim_code(ilim_code), .drv_cmd(drv_cmd),
  .ldo_on(ldo_on), .rst_out_n(rst_out_n)
);

// File: tb/pwr_seq_supervisor_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_supervisor_tb_top;
  localparam int STEP   = 4;
  localparam int LEVELS = 5;
  localparam int RSTT   = 20;
  localparam int ARMT   = 30;
  localparam int CW     = $clog2(LEVELS);

  logic clk = 1'b0;
  logic rst_n = 1'b0, tick = 1'b0, shdn_n = 1'b0, ldo_en = 1'b1;
  logic ov_flag = 1'b0, uv_flag = 1'b0, vin_uv = 1'b0, v5_uv = 1'b0;
  logic otemp = 1'b0, ldo_uv = 1'b0;
  logic [CW-1:0] ilim_code;
  logic [1:0]    drv_cmd;
  logic          ldo_on, rst_out_n;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  pwr_seq_supervisor #(
    .SS_STEP_TICKS(STEP), .SS_LEVELS(LEVELS),
    .RST_TICKS(RSTT), .UV_ARM_TICKS(ARMT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .shdn_n(shdn_n), .ldo_en(ldo_en),
    .ov_flag(ov_flag), .uv_flag(uv_flag), .vin_uv(vin_uv), .v5_uv(v5_uv),
    .otemp(otemp), .ldo_uv(ldo_uv), .ilim_code(ilim_code), .drv_cmd(drv_cmd),
    .ldo_on(ldo_on), .rst_out_n(rst_out_n)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic one_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    #1;
  endtask

  task automatic restart();
    @(negedge clk) shdn_n = 1'b0;
    #1 check("R1 drv in shutdown", int'(drv_cmd), 0);
    @(negedge clk) shdn_n = 1'b1;
    #1;
  endtask

  // kind: 0 overvoltage, 1 input supply UV, 2 bias supply UV
  task automatic fault_case(input int kind);
    string rq;
    rq = (kind == 0) ? "R5" : "R6";
    for (int i = 0; i < STEP; i++) one_tick();
    check("R9 code before fault", int'(ilim_code), 1);
    @(negedge clk);
    if (kind == 0) ov_flag = 1'b1; else if (kind == 1) vin_uv = 1'b1; else v5_uv = 1'b1;
    #1 check({rq, " lowon same cycle"}, int'(drv_cmd), 2);
    @(negedge clk) begin ov_flag = 1'b0; vin_uv = 1'b0; v5_uv = 1'b0; end
    #1 check({rq, " lowon latched"}, int'(drv_cmd), 2);
    check("R6 code zero in fault", int'(ilim_code), 0);
    check("R6 reset low in fault", int'(rst_out_n), 0);
    restart();
    check("R9 run after restart", int'(drv_cmd), 1);
    check("R9 code restarted", int'(ilim_code), 0);
    check("R9 reset low after restart", int'(rst_out_n), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 drv tri", int'(drv_cmd), 0);
    check("R1 reset low", int'(rst_out_n), 0);
    check("R1 code zero", int'(ilim_code), 0);
    check("R1 ldo off", int'(ldo_on), 0);
    @(negedge clk) shdn_n = 1'b1;
    #1 check("R1 run when active", int'(drv_cmd), 1);
    check("R8 ldo on", int'(ldo_on), 1);

    for (int n = 0; n <= ARMT + 10; n++) begin
      int exp_code;
      int rel;
      if (n > 0) one_tick();
      exp_code = (n / STEP > LEVELS - 1) ? LEVELS - 1 : n / STEP;
      rel = (n >= RSTT) ? 1 : 0;
      check("R2 R10 code", int'(ilim_code), exp_code);
      check("R3 reset release", int'(rst_out_n), rel);
      @(negedge clk) uv_flag = 1'b1;
      #1 check("R4 switcher uv", int'(rst_out_n), (rel == 1 && n < ARMT) ? 1 : 0);
      @(negedge clk) begin uv_flag = 1'b0; ldo_uv = 1'b1; end
      #1 check("R4 linear uv", int'(rst_out_n), (rel == 1 && n < ARMT) ? 1 : 0);
      @(negedge clk) ldo_en = 1'b0;
      #1 check("R8 linear uv masked", int'(rst_out_n), rel);
      check("R8 ldo off", int'(ldo_on), 0);
      check("R8 drv unaffected", int'(drv_cmd), 1);
      check("R8 code unaffected", int'(ilim_code), exp_code);
      @(negedge clk) begin ldo_en = 1'b1; ldo_uv = 1'b0; end
      #1;
    end
    check("R4 uv not latched", int'(rst_out_n), 1);

    restart();
    fault_case(0);
    restart();
    fault_case(1);
    restart();
    fault_case(2);

    for (int i = 0; i < STEP; i++) one_tick();
    @(negedge clk) otemp = 1'b1;
    #1 check("R7 tri on overtemp", int'(drv_cmd), 0);
    check("R7 code zero", int'(ilim_code), 0);
    check("R7 reset low", int'(rst_out_n), 0);
    @(negedge clk) otemp = 1'b0;
    #1 check("R7 run after cool", int'(drv_cmd), 1);
    check("R9 code cleared by overtemp", int'(ilim_code), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule